// File: doc/BRIEF.md
# Soft-Ramping Dual Gain Controller

This block scales a stereo stream of signed 24-bit samples by two independent gains, one for each channel. Each gain arrives as a 13-bit word made of a 5-bit exponent and an 8-bit mantissa. Together they cover roughly +24 dB down to about -138 dB, and a zero mantissa gives full silence. The gain words may change at any moment. The gain actually applied never jumps: on every sample strobe it moves a fixed fraction of its own value toward the requested gain. The transition is therefore exponential in level and produces no audible click. If the request changes mid-transition, the ramp turns toward the newest value at once.

A mute request overrides both targets with zero, so the level decays along the same exponential curve. Releasing the mute ramps the level back up. A 2-bit field selects an output ceiling in 6 dB steps, and the rounded product is clamped to it. A per-channel busy flag shows that the applied gain has not yet reached its target.

Top module: `dual_gain_ramp`

## Requirements
- R1: A gain word holds the exponent in bits [12:8] and the mantissa in bits [7:0]. The linear gain is mantissa/128 × 2^(exponent−16), so 0x1080 is unity. An exponent above 19 acts as 19.
- R2: The left and right channels use their own gain word, ramp and busy flag, and neither channel affects the other.
- R3: Once the ramp has settled on a zero mantissa, the channel output is exactly zero for any input sample.
- R4: Each output is the sample times the applied gain, rounded half up, then clamped. The upper bound is (2^23−1) >> limit_sel and the lower bound is its bitwise complement. A limit_sel of 0 gives full scale, 1 gives −6 dB, 2 gives −12 dB and 3 gives −18 dB.
- R5: Each strobe produces an output one clock later, with out_valid high for exactly that clock. The output uses the applied gain held before the strobe. On each strobe the applied gain moves toward the target by max(applied >> 4, 1), or lands on the target if it is within that distance. Without a strobe the applied gain does not change.
- R6: A gain word change during a ramp takes effect on the next strobe after the word has been registered (two clocks). The ramp then heads straight for the newest value and settles there.
- R7: While mute_req is high both targets are zero and the level decays by 1/16 per strobe. When mute_req is released, the level ramps back up to the gain words.
- R8: busy_l or busy_r is high exactly while that channel's applied gain differs from its registered target. It rises one clock after a gain word change.
- R9: Reset clears the applied gains to zero and drives out_valid, out_l and out_r low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe, one clock per sample pair |
| smp_l | input | 24 | Left input sample, two's complement |
| smp_r | input | 24 | Right input sample, two's complement |
| gain_l | input | 13 | Left gain word (exponent [12:8], mantissa [7:0]) |
| gain_r | input | 13 | Right gain word |
| mute_req | input | 1 | Soft mute request for both channels |
| limit_sel | input | 2 | Output ceiling select, 6 dB per step |
| out_valid | output | 1 | Output samples valid |
| out_l | output | 24 | Left scaled, limited sample |
| out_r | output | 24 | Right scaled, limited sample |
| busy_l | output | 1 | Left gain still ramping |
| busy_r | output | 1 | Right gain still ramping |

## Verification
The settled gain path is tried with a table of gain pairs that use a different word on each channel. These separate exponent and mantissa decoding, clamping of the exponent at 19, half-up rounding of odd products, and each ceiling setting on positive and negative full-range samples. The ramp is tried by stepping from unity toward double gain with constant samples. The exact step values separate the multiplicative step from a linear one, and a gap without strobes shows that the ramp waits for samples. A reversal in the middle of that ramp separates "head for the newest value" from "finish the old ramp first". A mute-and-release sequence confirms the 15/16 decay and exact silence, with the busy flags checked throughout.

// File: rtl/gc_pkg.sv
package gc_pkg;
    localparam int IDX_W  = 5;
    localparam int MANT_W = 8;
    localparam int WORD_W = IDX_W + MANT_W;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/gc_gain_decode.sv
module gc_gain_decode
    import gc_pkg::*;
#(
    parameter int IDX_MAX = 19,
    parameter int GW      = MANT_W + IDX_MAX
) (
    input  logic [WORD_W-1:0] word,
    input  logic              mute,
    output logic [GW-1:0]     lin
);
    logic [IDX_W-1:0]  idx;
    logic [MANT_W-1:0] mant;
    logic [IDX_W-1:0]  idx_eff;

    always_comb begin
        idx     = word[WORD_W-1:MANT_W];
        mant    = word[MANT_W-1:0];
        idx_eff = (int'(idx) > IDX_MAX) ? IDX_W'(IDX_MAX) : idx;
        lin     = mute ? '0 : ({{(GW-MANT_W){1'b0}}, mant} << idx_eff);
    end

    // R3: a zero mantissa never yields a non-zero linear gain
    always_comb begin
        if (mant == '0) begin
            p_zero_mant_r3: assert (lin == '0);
        end
    end
endmodule

// File: rtl/gc_ramp.sv
module gc_ramp
    import gc_pkg::*;
#(
    parameter int GW      = 27,
    parameter int STEP_SH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [GW-1:0] tgt_in,
    output logic [GW-1:0] app,
    output logic          busy
);
    typedef struct packed {
        logic [GW-1:0] tgt;
        logic [GW-1:0] app;
    } ramp_st_t;

    ramp_st_t  st_d, st_q;
    ramp_dir_e dir;
    logic [GW-1:0] step, gap;

    always_comb begin
        st_d     = st_q;
        st_d.tgt = tgt_in;
        step     = st_q.app >> STEP_SH;
        if (step == '0) step = GW'(1);
        if (st_q.app < st_q.tgt) begin
            dir = RAMP_UP;
            gap = st_q.tgt - st_q.app;
        end else if (st_q.app > st_q.tgt) begin
            dir = RAMP_DOWN;
            gap = st_q.app - st_q.tgt;
        end else begin
            dir = RAMP_HOLD;
            gap = '0;
        end
        if (strobe) begin
            case (dir)
                RAMP_UP:   st_d.app = (gap <= step) ? st_q.tgt : st_q.app + step;
                RAMP_DOWN: st_d.app = (gap <= step) ? st_q.tgt : st_q.app - step;
                default:   st_d.app = st_q.app;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign app  = st_q.app;
    assign busy = (st_q.app != st_q.tgt);

    // R5: the applied gain only moves on a sample strobe
    p_hold_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(app));

    // R6: an upward step never overshoots the target that was in force
    p_no_overshoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && app < st_q.tgt) |=> (app > $past(app)) && (app <= $past(st_q.tgt)));

    // R7: a downward step never undershoots the target that was in force
    p_no_undershoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && app > st_q.tgt) |=> (app < $past(app)) && (app >= $past(st_q.tgt)));

    // R8: a settled channel stays put on a strobe
    p_settled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !busy) |=> $stable(app));
endmodule

// File: rtl/gc_scale.sv
module gc_scale #(
    parameter int DW   = 24,
    parameter int GW   = 27,
    parameter int FRAC = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [DW-1:0] sample,
    input  logic [GW-1:0] gain,
    input  logic [1:0]    lim_sel,
    output logic [DW-1:0] out
);
    localparam int PW = DW + GW + 1;
    localparam logic [DW-1:0] MAXP = {1'b0, {(DW-1){1'b1}}};

    typedef struct packed {
        logic [DW-1:0] out;
    } scale_st_t;

    scale_st_t st_d, st_q;
    logic signed [PW-1:0] prod, half, rnd, hi, lo;
    logic [DW-1:0] ceil_v;

    always_comb begin
        st_d   = st_q;
        prod   = PW'($signed(sample)) * $signed({{(PW-GW){1'b0}}, gain});
        half   = PW'(1) << (FRAC - 1);
        rnd    = (prod + half) >>> FRAC;
        ceil_v = MAXP >> lim_sel;
        hi     = $signed({{(PW-DW){1'b0}}, ceil_v});
        lo     = ~hi;
        if (strobe) begin
            if (rnd > hi)      st_d.out = hi[DW-1:0];
            else if (rnd < lo) st_d.out = lo[DW-1:0];
            else               st_d.out = rnd[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out = st_q.out;

    // R4: a fresh output stays within the ceiling chosen at its strobe
    p_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> ($signed(out) <= $signed(MAXP >> $past(lim_sel)))
               && ($signed(out) >= $signed(~(MAXP >> $past(lim_sel)))));

    // R3: a zero applied gain gives an exact zero
    p_zero_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && gain == '0) |=> (out == '0));
endmodule

// File: rtl/dual_gain_ramp.sv
module dual_gain_ramp
    import gc_pkg::*;
#(
    parameter int DW       = 24,
    parameter int IDX_MAX  = 19,
    parameter int IDX_BIAS = 16,
    parameter int STEP_SH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DW-1:0]     smp_l,
    input  logic [DW-1:0]     smp_r,
    input  logic [WORD_W-1:0] gain_l,
    input  logic [WORD_W-1:0] gain_r,
    input  logic              mute_req,
    input  logic [1:0]        limit_sel,
    output logic              out_valid,
    output logic [DW-1:0]     out_l,
    output logic [DW-1:0]     out_r,
    output logic              busy_l,
    output logic              busy_r
);
    localparam int NCH  = 2;
    localparam int GW   = MANT_W + IDX_MAX;
    localparam int FRAC = MANT_W - 1 + IDX_BIAS;

    typedef struct packed {
        logic valid;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [WORD_W-1:0] word_a [NCH];
    logic [DW-1:0]     smp_a  [NCH];
    logic [DW-1:0]     out_a  [NCH];
    logic [GW-1:0]     tgt_a  [NCH];
    logic [GW-1:0]     app_a  [NCH];
    logic [NCH-1:0]    busy_a;

    assign word_a[0] = gain_l;
    assign word_a[1] = gain_r;
    assign smp_a[0]  = smp_l;
    assign smp_a[1]  = smp_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gc_gain_decode #(.IDX_MAX(IDX_MAX), .GW(GW)) u_dec (
            .word (word_a[c]),
            .mute (mute_req),
            .lin  (tgt_a[c])
        );
        gc_ramp #(.GW(GW), .STEP_SH(STEP_SH)) u_ramp (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (smp_valid),
            .tgt_in (tgt_a[c]),
            .app    (app_a[c]),
            .busy   (busy_a[c])
        );
        gc_scale #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_scale (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe  (smp_valid),
            .sample  (smp_a[c]),
            .gain    (app_a[c]),
            .lim_sel (limit_sel),
            .out     (out_a[c])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = smp_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_l     = out_a[0];
    assign out_r     = out_a[1];
    assign busy_l    = busy_a[0];
    assign busy_r    = busy_a[1];

    // R5: one valid output per strobe, one clock later
    p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    p_valid_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);
endmodule

// File: tb/tb_dual_gain_ramp.sv
module tb_dual_gain_ramp;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [12:0] gl;
        logic [12:0] gr;
        logic [1:0]  lim;
        logic [23:0] sl;
        logic [23:0] sr;
        logic [23:0] el;
        logic [23:0] er;
    } vec_t;

    // gain words: 0x1080 unity, 0x1180 x2, 0x0F80 x0.5, 0x1000 zero mantissa,
    // 0x1F80 exponent 31 (acts as 19, x8), 0x1380 x8, 0x10FF x255/128
    localparam vec_t TABLE [8] = '{
        '{13'h1080, 13'h1080, 2'd0, 24'd1000,    24'hFFF448, 24'd1000,    24'hFFF448},
        '{13'h1180, 13'h0F80, 2'd0, 24'hFFF448,  24'd7,      24'hFFE890,  24'd4},
        '{13'h1180, 13'h1180, 2'd0, 24'h500000,  24'hB00000, 24'h7FFFFF,  24'h800000},
        '{13'h1000, 13'h1080, 2'd0, 24'h7FFFFF,  24'h123456, 24'h000000,  24'h123456},
        '{13'h1080, 13'h1080, 2'd1, 24'h300000,  24'hD00000, 24'h300000,  24'hD00000},
        '{13'h1080, 13'h1080, 2'd2, 24'h300000,  24'hD00000, 24'h1FFFFF,  24'hE00000},
        '{13'h1F80, 13'h1380, 2'd0, 24'd100,     24'd100,    24'd800,     24'd800},
        '{13'h10FF, 13'h1180, 2'd3, 24'd128,     24'h200000, 24'd255,     24'h0FFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_l = '0, smp_r = '0;
    logic [12:0] gain_l = '0, gain_r = '0;
    logic        mute_req = 1'b0;
    logic [1:0]  limit_sel = '0;
    logic        out_valid, busy_l, busy_r;
    logic [23:0] out_l, out_r;

    int n_chk = 0;
    int n_fail = 0;

    dual_gain_ramp dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_l(smp_l), .smp_r(smp_r), .gain_l(gain_l), .gain_r(gain_r),
        .mute_req(mute_req), .limit_sel(limit_sel), .out_valid(out_valid),
        .out_l(out_l), .out_r(out_r), .busy_l(busy_l), .busy_r(busy_r)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_l = l;
        smp_r = r;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4000 && (busy_l || busy_r); i++) strobe('0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] prev;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({23'b0, out_valid}, 24'd0, "R9 out_valid in reset");
        chk(out_l, 24'd0, "R9 out_l in reset");
        chk(out_r, 24'd0, "R9 out_r in reset");
        chk({23'b0, busy_l}, 24'd0, "R9 busy_l in reset");
        rst_n = 1'b1;

        // table of settled gain cases: R1 R2 R3 R4
        for (int i = 0; i < 8; i++) begin
            gain_l = TABLE[i].gl;
            gain_r = TABLE[i].gr;
            limit_sel = TABLE[i].lim;
            settle();
            strobe(TABLE[i].sl, TABLE[i].sr);
            chk({23'b0, out_valid}, 24'd1, $sformatf("R5 valid after strobe row %0d", i));
            chk(out_l, TABLE[i].el, $sformatf("R1 R3 R4 left row %0d", i));
            chk(out_r, TABLE[i].er, $sformatf("R1 R2 R4 right row %0d", i));
            @(negedge clk);
            chk({23'b0, out_valid}, 24'd0, $sformatf("R5 valid one clock row %0d", i));
        end

        // R5 ramp from unity toward x2 on left only
        limit_sel = 2'd0;
        gain_l = 13'h1080;
        gain_r = 13'h1080;
        settle();
        gain_l = 13'h1180;
        repeat (2) @(negedge clk);
        chk({23'b0, busy_l}, 24'd1, "R8 busy_l after change");
        chk({23'b0, busy_r}, 24'd0, "R2 busy_r untouched");
        strobe(24'd65536, 24'd65536);
        chk(out_l, 24'd65536, "R5 first output uses old gain");
        strobe(24'd65536, 24'd65536);
        chk(out_l, 24'd69632, "R5 one multiplicative step");
        chk(out_r, 24'd65536, "R2 right unaffected by left ramp");
        repeat (10) @(negedge clk);
        strobe(24'd65536, 24'd65536);
        chk(out_l, 24'd73984, "R5 no step without strobe");

        // R6 retarget mid-ramp to x0.5
        gain_l = 13'h0F80;
        repeat (2) @(negedge clk);
        strobe(24'd65536, 24'd65536);
        chk(out_l, 24'd78608, "R6 last upward value");
        prev = out_l;
        strobe(24'd65536, 24'd65536);
        chk(out_l, 24'd73695, "R6 turns toward newest target");
        chk({23'b0, (out_l < prev)}, 24'd1, "R6 level now falling");
        settle();
        strobe(24'd65536, 24'd65536);
        chk(out_l, 24'd32768, "R6 settles on newest target");
        chk({23'b0, busy_l}, 24'd0, "R8 busy_l low when settled");

        // R7 soft mute and release
        gain_l = 13'h1080;
        settle();
        mute_req = 1'b1;
        repeat (2) @(negedge clk);
        chk({23'b0, busy_r}, 24'd1, "R7 R8 busy_r on mute");
        strobe(24'd65536, 24'd65536);
        chk(out_l, 24'd65536, "R7 mute first output");
        strobe(24'd65536, 24'd65536);
        chk(out_l, 24'd61440, "R7 decay step one");
        strobe(24'd65536, 24'd65536);
        chk(out_r, 24'd57600, "R7 decay step two");
        settle();
        strobe(24'h7FFFFF, 24'h800000);
        chk(out_l, 24'd0, "R7 muted left exact zero");
        chk(out_r, 24'd0, "R7 muted right exact zero");
        mute_req = 1'b0;
        repeat (2) @(negedge clk);
        chk({23'b0, busy_l}, 24'd1, "R7 R8 busy on release");
        settle();
        strobe(24'd65536, 24'd65536);
        chk(out_l, 24'd65536, "R7 back at unity after release");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule